// File: doc/BRIEF.md
# Register Window Spill/Fill Trap Unit

This block keeps the window bookkeeping state of a processor with a ring of register windows. It holds the current window pointer and three occupancy counts: windows still free to save into, windows that hold caller state and can be restored into, and windows that belong to another address space. It also holds a window-state register with two 3-bit vector-select fields, one for normal use and one for the other address space. A save or restore request either moves the pointer and updates the counts, or, when the relevant count is zero, raises a trap instead. On a trap the block reports a trap type number and moves the pointer to the window that the handler must store to or load from memory.

The handler ends with a "saved" or "restored" completion strobe. These rebalance the counts so that the trapped instruction can be retried without trapping again. Privileged writes load any of the state registers directly. One operation is performed per clock, picked by a fixed priority when several strobes coincide. Trap results are registered and appear one cycle after the request.

Top module: `win_trap_unit`

## Requirements
- R1: While reset is asserted and right after it: pointer 0, free-to-save count NWIN-2, restorable count 0, other-space count 0, both select fields 0, trap_vld 0.
- R2: A save with free-to-save count nonzero raises no trap, advances the pointer by one modulo NWIN, decrements the free-to-save count and increments the restorable count.
- R3: A restore with restorable count nonzero raises no trap, moves the pointer back by one modulo NWIN, increments the free-to-save count and decrements the restorable count.
- R4: A save with free-to-save count zero raises a spill trap, leaves all three counts unchanged and sets the pointer to (pointer + 2) modulo NWIN.
- R5: A restore with restorable count zero raises a fill trap, leaves all three counts unchanged and sets the pointer to (pointer - 1) modulo NWIN.
- R6: The trap type is 8 bits: bit 7 is 1, bit 6 is 1 for fill and 0 for spill, bit 5 is 1 when the other-space count is nonzero, bits 4:2 hold the other-space select field when that count is nonzero and the normal select field otherwise, bits 1:0 are 0. This gives 0x80+4n, 0xA0+4n, 0xC0+4n and 0xE0+4n.
- R7: trap_vld is high for exactly the cycle after a trapping request and low otherwise; trap_type changes only when a trap is raised and holds its value in between.
- R8: The saved strobe increments the free-to-save count, then decrements the other-space count if it is nonzero, or else the restorable count; the pointer is unchanged.
- R9: The restored strobe increments the restorable count, then decrements the other-space count if it is nonzero, or else the free-to-save count; the pointer is unchanged.
- R10: With wr_en high, wr_sel selects the target: 0 pointer, 1 free-to-save count, 2 restorable count, 3 other-space count, 4 select fields (wr_data[2:0] normal, wr_data[5:3] other-space). Counts and pointer take the low bits of wr_data. Codes 5 to 7 change nothing.
- R11: When strobes coincide only one operation runs, in priority order: write, save, restore, saved, restored; the others that cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_req | input | 1 | Save request strobe |
| restore_req | input | 1 | Restore request strobe |
| saved_op | input | 1 | Spill-handler completion strobe |
| restored_op | input | 1 | Fill-handler completion strobe |
| wr_en | input | 1 | Privileged register write strobe |
| wr_sel | input | 3 | Write target code |
| wr_data | input | 6 | Write data |
| trap_vld | output | 1 | Trap raised by the previous cycle's request |
| trap_type | output | 8 | Trap type number of the last trap |
| cwp | output | $clog2(NWIN) | Current window pointer |
| cansave | output | $clog2(NWIN) | Windows free to save into |
| canrestore | output | $clog2(NWIN) | Windows available to restore into |
| otherwin | output | $clog2(NWIN) | Windows owned by the other address space |
| wsel_norm | output | 3 | Normal vector-select field |
| wsel_oth | output | 3 | Other-space vector-select field |

## Verification
The bench builds the block with NWIN = 6, so the pointer wraps at a value that is not a power of two and every wrap must come from the modulo logic rather than a natural bit overflow, while the counts stay three bits wide. With this small ring all 64 pairs of select-field values are swept for both spill and fill, with the other-space count zero and nonzero, at varying pointer positions that include the wrap points. A full walk around the ring, the handler completion strobes, ignored write codes and coinciding strobes are checked against an arithmetic model in the bench.

// File: rtl/wtu_pkg.sv
package wtu_pkg;

  localparam int FIELD_W = 3;
  localparam int TT_W    = 8;
  localparam int WDATA_W = 6;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CWP        = 3'd0,
    SEL_CANSAVE    = 3'd1,
    SEL_CANRESTORE = 3'd2,
    SEL_OTHERWIN   = 3'd3,
    SEL_WSTATE     = 3'd4
  } reg_sel_e;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WRITE,
    OP_SAVE,
    OP_RESTORE,
    OP_SAVED,
    OP_RESTORED
  } op_e;

  // Trap number layout: family base in bits 7:5, vector index in 4:2.
  function automatic logic [TT_W-1:0] make_tt(input logic is_fill,
                                               input logic is_other,
                                               input logic [FIELD_W-1:0] idx);
    return {1'b1, is_fill, is_other, idx, 2'b00};
  endfunction

endpackage

// File: rtl/wtu_op_decode.sv
module wtu_op_decode
  import wtu_pkg::*;
(
  input  logic wr_en,
  input  logic save_req,
  input  logic restore_req,
  input  logic saved_op,
  input  logic restored_op,
  output op_e  op
);

  always_comb begin
    if (wr_en)            op = OP_WRITE;
    else if (save_req)    op = OP_SAVE;
    else if (restore_req) op = OP_RESTORE;
    else if (saved_op)    op = OP_SAVED;
    else if (restored_op) op = OP_RESTORED;
    else                  op = OP_IDLE;
  end

endmodule

// File: rtl/wtu_vec_enc.sv
module wtu_vec_enc
  import wtu_pkg::*;
(
  input  logic               is_fill,
  input  logic               other_live,
  input  logic [FIELD_W-1:0] sel_norm,
  input  logic [FIELD_W-1:0] sel_oth,
  output logic [TT_W-1:0]    tt
);

  logic [FIELD_W-1:0] idx;

  always_comb begin
    idx = other_live ? sel_oth : sel_norm;
    tt  = make_tt(is_fill, other_live, idx);
  end

endmodule

// File: rtl/wtu_next_state.sv
module wtu_next_state
  import wtu_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  localparam int unsigned PW  = $clog2(NWIN)
) (
  input  op_e                op,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [WDATA_W-1:0] wr_data,
  input  logic [PW-1:0]      cur_cwp,
  input  logic [PW-1:0]      cur_cs,
  input  logic [PW-1:0]      cur_cr,
  input  logic [PW-1:0]      cur_ow,
  input  logic [FIELD_W-1:0] cur_wn,
  input  logic [FIELD_W-1:0] cur_wo,
  output logic [PW-1:0]      nxt_cwp,
  output logic [PW-1:0]      nxt_cs,
  output logic [PW-1:0]      nxt_cr,
  output logic [PW-1:0]      nxt_ow,
  output logic [FIELD_W-1:0] nxt_wn,
  output logic [FIELD_W-1:0] nxt_wo,
  output logic               trap_fire,
  output logic               trap_fill
);

  localparam logic [PW-1:0] ONE = PW'(1);

  function automatic logic [PW-1:0] ring_add(input logic [PW-1:0] p,
                                             input int unsigned d);
    int unsigned s;
    s = (32'(p) + d) % NWIN;
    return s[PW-1:0];
  endfunction

  logic ow_live;
  assign ow_live = (cur_ow != '0);

  always_comb begin
    nxt_cwp   = cur_cwp;
    nxt_cs    = cur_cs;
    nxt_cr    = cur_cr;
    nxt_ow    = cur_ow;
    nxt_wn    = cur_wn;
    nxt_wo    = cur_wo;
    trap_fire = 1'b0;
    trap_fill = 1'b0;
    unique case (op)
      OP_WRITE: begin
        case (reg_sel_e'(wr_sel))
          SEL_CWP:        nxt_cwp = ring_add(wr_data[PW-1:0], 0);
          SEL_CANSAVE:    nxt_cs  = wr_data[PW-1:0];
          SEL_CANRESTORE: nxt_cr  = wr_data[PW-1:0];
          SEL_OTHERWIN:   nxt_ow  = wr_data[PW-1:0];
          SEL_WSTATE: begin
            nxt_wn = wr_data[FIELD_W-1:0];
            nxt_wo = wr_data[2*FIELD_W-1:FIELD_W];
          end
          default: ;
        endcase
      end
      OP_SAVE: begin
        if (cur_cs == '0) begin
          trap_fire = 1'b1;
          nxt_cwp   = ring_add(cur_cwp, 2);
        end else begin
          nxt_cwp = ring_add(cur_cwp, 1);
          nxt_cs  = cur_cs - ONE;
          nxt_cr  = cur_cr + ONE;
        end
      end
      OP_RESTORE: begin
        if (cur_cr == '0) begin
          trap_fire = 1'b1;
          trap_fill = 1'b1;
          nxt_cwp   = ring_add(cur_cwp, NWIN - 1);
        end else begin
          nxt_cwp = ring_add(cur_cwp, NWIN - 1);
          nxt_cs  = cur_cs + ONE;
          nxt_cr  = cur_cr - ONE;
        end
      end
      OP_SAVED: begin
        nxt_cs = cur_cs + ONE;
        if (ow_live) nxt_ow = cur_ow - ONE;
        else         nxt_cr = cur_cr - ONE;
      end
      OP_RESTORED: begin
        nxt_cr = cur_cr + ONE;
        if (ow_live) nxt_ow = cur_ow - ONE;
        else         nxt_cs = cur_cs - ONE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/win_trap_unit.sv
module win_trap_unit
  import wtu_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  localparam int unsigned PW  = $clog2(NWIN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               save_req,
  input  logic               restore_req,
  input  logic               saved_op,
  input  logic               restored_op,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [WDATA_W-1:0] wr_data,
  output logic               trap_vld,
  output logic [TT_W-1:0]    trap_type,
  output logic [PW-1:0]      cwp,
  output logic [PW-1:0]      cansave,
  output logic [PW-1:0]      canrestore,
  output logic [PW-1:0]      otherwin,
  output logic [FIELD_W-1:0] wsel_norm,
  output logic [FIELD_W-1:0] wsel_oth
);

  localparam logic [PW-1:0] CS_RESET = PW'(NWIN - 2);

  op_e               op;
  logic [PW-1:0]     nxt_cwp, nxt_cs, nxt_cr, nxt_ow;
  logic [FIELD_W-1:0] nxt_wn, nxt_wo;
  logic              trap_fire, trap_fill;
  logic [TT_W-1:0]   tt_d;
  logic              state_en;

  wtu_op_decode u_dec (
    .wr_en       (wr_en),
    .save_req    (save_req),
    .restore_req (restore_req),
    .saved_op    (saved_op),
    .restored_op (restored_op),
    .op          (op)
  );

  wtu_next_state #(.NWIN(NWIN)) u_nxt (
    .op        (op),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .cur_cwp   (cwp),
    .cur_cs    (cansave),
    .cur_cr    (canrestore),
    .cur_ow    (otherwin),
    .cur_wn    (wsel_norm),
    .cur_wo    (wsel_oth),
    .nxt_cwp   (nxt_cwp),
    .nxt_cs    (nxt_cs),
    .nxt_cr    (nxt_cr),
    .nxt_ow    (nxt_ow),
    .nxt_wn    (nxt_wn),
    .nxt_wo    (nxt_wo),
    .trap_fire (trap_fire),
    .trap_fill (trap_fill)
  );

  wtu_vec_enc u_vec (
    .is_fill    (trap_fill),
    .other_live (otherwin != '0),
    .sel_norm   (wsel_norm),
    .sel_oth    (wsel_oth),
    .tt         (tt_d)
  );

  assign state_en = (op != OP_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp        <= '0;
      cansave    <= CS_RESET;
      canrestore <= '0;
      otherwin   <= '0;
      wsel_norm  <= '0;
      wsel_oth   <= '0;
    end else if (state_en) begin
      cwp        <= nxt_cwp;
      cansave    <= nxt_cs;
      canrestore <= nxt_cr;
      otherwin   <= nxt_ow;
      wsel_norm  <= nxt_wn;
      wsel_oth   <= nxt_wo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_vld  <= 1'b0;
      trap_type <= '0;
    end else begin
      trap_vld <= trap_fire;
      if (trap_fire) trap_type <= tt_d;
    end
  end

endmodule

// File: rtl/wtu_checker.sv
module wtu_checker
  import wtu_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  localparam int unsigned PW  = $clog2(NWIN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            save_req,
  input logic            restore_req,
  input logic            saved_op,
  input logic            restored_op,
  input logic            wr_en,
  input logic            trap_vld,
  input logic [TT_W-1:0] trap_type,
  input logic [PW-1:0]   cwp,
  input logic [PW-1:0]   cansave,
  input logic [PW-1:0]   canrestore,
  input logic [PW-1:0]   otherwin
);

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p,
                                             input int unsigned d);
    int unsigned s;
    s = (32'(p) + d) % NWIN;
    return s[PW-1:0];
  endfunction

  p_save_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && save_req && cansave != '0) |=>
      (!trap_vld && cwp == step_ptr($past(cwp), 1) &&
       cansave == $past(cansave) - PW'(1) &&
       canrestore == $past(canrestore) + PW'(1)));

  p_restore_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !save_req && restore_req && canrestore != '0) |=>
      (!trap_vld && cwp == step_ptr($past(cwp), NWIN - 1)));

  p_spill_holds_counts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && save_req && cansave == '0) |=>
      (trap_vld && !trap_type[6] && cansave == $past(cansave) &&
       canrestore == $past(canrestore) && otherwin == $past(otherwin) &&
       cwp == step_ptr($past(cwp), 2)));

  p_fill_holds_counts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !save_req && restore_req && canrestore == '0) |=>
      (trap_vld && trap_type[6] && cansave == $past(cansave) &&
       cwp == step_ptr($past(cwp), NWIN - 1)));

  p_type_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld |-> (trap_type[7] && trap_type[1:0] == 2'b00));

  p_vld_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld |-> $past(!wr_en && (save_req || restore_req)));

  p_type_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_vld |-> $stable(trap_type));

  p_saved_bumps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !save_req && !restore_req && saved_op) |=>
      (cansave == $past(cansave) + PW'(1) && $stable(cwp)));

endmodule

bind win_trap_unit wtu_checker #(.NWIN(NWIN)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .save_req    (save_req),
  .restore_req (restore_req),
  .saved_op    (saved_op),
  .restored_op (restored_op),
  .wr_en       (wr_en),
  .trap_vld    (trap_vld),
  .trap_type   (trap_type),
  .cwp         (cwp),
  .cansave     (cansave),
  .canrestore  (canrestore),
  .otherwin    (otherwin)
);

// File: tb/win_trap_unit_tb_top.sv
`timescale 1ns/1ps
module win_trap_unit_tb_top;

  localparam int NW = 6;
  localparam int PW = $clog2(NW);
  localparam int CMOD = 1 << PW;

  logic clk = 1'b0;
  logic rst_n;
  logic save_req, restore_req, saved_op, restored_op, wr_en;
  logic [2:0] wr_sel;
  logic [5:0] wr_data;
  logic trap_vld;
  logic [7:0] trap_type;
  logic [PW-1:0] cwp, cansave, canrestore, otherwin;
  logic [2:0] wsel_norm, wsel_oth;

  always #2 clk = ~clk;

  win_trap_unit #(.NWIN(NW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .save_req(save_req), .restore_req(restore_req),
    .saved_op(saved_op), .restored_op(restored_op),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .trap_vld(trap_vld), .trap_type(trap_type),
    .cwp(cwp), .cansave(cansave), .canrestore(canrestore),
    .otherwin(otherwin), .wsel_norm(wsel_norm), .wsel_oth(wsel_oth)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int m_cwp, m_cs, m_cr, m_ow, m_wn, m_wo, m_tt, m_vld;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "trap_vld",   int'(trap_vld),   m_vld);
    chk(tag, "trap_type",  int'(trap_type),  m_tt);
    chk(tag, "cwp",        int'(cwp),        m_cwp);
    chk(tag, "cansave",    int'(cansave),    m_cs);
    chk(tag, "canrestore", int'(canrestore), m_cr);
    chk(tag, "otherwin",   int'(otherwin),   m_ow);
    chk(tag, "wsel_norm",  int'(wsel_norm),  m_wn);
    chk(tag, "wsel_oth",   int'(wsel_oth),   m_wo);
  endtask

  // Apply one cycle of stimulus, update the model, compare after the edge.
  task automatic step(input bit s, input bit r, input bit sv, input bit rs,
                      input bit we, input int sel, input int d, input string tag);
    int idx;
    save_req = s; restore_req = r; saved_op = sv; restored_op = rs;
    wr_en = we; wr_sel = 3'(sel); wr_data = 6'(d);
    @(posedge clk);
    @(negedge clk);
    save_req = 0; restore_req = 0; saved_op = 0; restored_op = 0; wr_en = 0;
    m_vld = 0;
    if (we) begin
      case (sel)
        0: m_cwp = (d % CMOD) % NW;
        1: m_cs  = d % CMOD;
        2: m_cr  = d % CMOD;
        3: m_ow  = d % CMOD;
        4: begin m_wn = d % 8; m_wo = (d / 8) % 8; end
        default: ;
      endcase
    end else if (s) begin
      if (m_cs == 0) begin
        idx = (m_ow != 0) ? m_wo : m_wn;
        m_tt = 'h80 + ((m_ow != 0) ? 'h20 : 0) + 4 * idx;
        m_vld = 1;
        m_cwp = (m_cwp + 2) % NW;
      end else begin
        m_cwp = (m_cwp + 1) % NW;
        m_cs = (m_cs + CMOD - 1) % CMOD;
        m_cr = (m_cr + 1) % CMOD;
      end
    end else if (r) begin
      if (m_cr == 0) begin
        idx = (m_ow != 0) ? m_wo : m_wn;
        m_tt = 'hC0 + ((m_ow != 0) ? 'h20 : 0) + 4 * idx;
        m_vld = 1;
        m_cwp = (m_cwp + NW - 1) % NW;
      end else begin
        m_cwp = (m_cwp + NW - 1) % NW;
        m_cs = (m_cs + 1) % CMOD;
        m_cr = (m_cr + CMOD - 1) % CMOD;
      end
    end else if (sv) begin
      m_cs = (m_cs + 1) % CMOD;
      if (m_ow != 0) m_ow = m_ow - 1;
      else           m_cr = (m_cr + CMOD - 1) % CMOD;
    end else if (rs) begin
      m_cr = (m_cr + 1) % CMOD;
      if (m_ow != 0) m_ow = m_ow - 1;
      else           m_cs = (m_cs + CMOD - 1) % CMOD;
    end
    chk_all(tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    save_req = 0; restore_req = 0; saved_op = 0; restored_op = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
    m_cwp = 0; m_cs = NW - 2; m_cr = 0; m_ow = 0; m_wn = 0; m_wo = 0;
    m_tt = 0; m_vld = 0;
    repeat (3) @(negedge clk);
    chk_all("R1");
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, "R1");

    // Walk around the ring: saves until full, spill, then drain with restores.
    for (int i = 0; i < NW - 2; i++) step(1, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 0, 0, 0, 0, "R8");
    step(1, 0, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < NW - 2; i++) step(0, 1, 0, 0, 0, 0, 0, "R3");
    step(0, 1, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 0, 0, 0, "R9");
    step(1, 0, 0, 0, 0, 0, 0, "R7");

    // Pointer wrap at the top of a ring that is not a power of two.
    step(0, 0, 0, 0, 1, 0, NW - 1, "R10");
    step(0, 0, 0, 0, 1, 1, 2, "R10");
    step(0, 0, 0, 0, 1, 2, 2, "R10");
    step(1, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 1, 0, 0, 0, 0, 0, "R3");
    step(0, 1, 0, 0, 0, 0, 0, "R3");

    // Ignored write codes.
    for (int c = 5; c < 8; c++) step(0, 0, 0, 0, 1, c, 'h3F, "R10");

    // Coinciding strobes.
    step(1, 1, 1, 1, 1, 1, 3, "R11");
    step(1, 1, 1, 1, 0, 0, 0, "R11");
    step(0, 1, 1, 1, 0, 0, 0, "R11");
    step(0, 0, 1, 1, 0, 0, 0, "R11");

    // Sweep of every select-field pair for spill and fill, both families.
    for (int n = 0; n < 8; n++) begin
      for (int m = 0; m < 8; m++) begin
        for (int ow = 0; ow < 2; ow++) begin
          step(0, 0, 0, 0, 1, 4, m * 8 + n, "R10");
          step(0, 0, 0, 0, 1, 3, ow, "R10");
          step(0, 0, 0, 0, 1, 0, (n + m + ow) % NW, "R10");
          step(0, 0, 0, 0, 1, 1, 0, "R10");
          step(0, 0, 0, 0, 1, 2, 2, "R10");
          step(1, 0, 0, 0, 0, 0, 0, "R6");
          step(0, 0, 1, 0, 0, 0, 0, "R8");
          step(0, 0, 0, 0, 1, 3, ow, "R10");
          step(0, 0, 0, 0, 1, 2, 0, "R10");
          step(0, 0, 0, 0, 1, 1, 2, "R10");
          step(0, 1, 0, 0, 0, 0, 0, "R6");
          step(0, 0, 0, 1, 0, 0, 0, "R9");
        end
      end
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule